// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block protects an in-order five-stage pipeline from the one dependency that forwarding cannot cover. The case is an instruction in decode that reads a register which the load now in execute has not yet brought back from data memory. The loaded value only exists after the memory stage. So the dependent instruction has to wait exactly one cycle, and after that it can take the value from the forwarding path.

While the condition holds, the block lowers the write enables of the program counter and of the fetch/decode register. This keeps the same instruction in fetch and in decode. In the same cycle it asserts a clear. The clear zeroes the execute, memory and write-back control fields that enter the decode/execute register, so a harmless bubble moves down the pipe. On the next cycle the load has moved on and the condition drops by itself.

The stall detector is wrapped with a small program counter, a fetch/decode register and a decode/execute register. These carry only the fields the detector needs, so the stall behaviour can be observed over time. The fetched instruction fields enter through ports, as if they came from an instruction memory that the surrounding logic addresses with `pc_q`.

Top module: `ldu_stall_pipe`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0, the held instruction fields and all decode/execute control bits, and leaves the stall signals inactive.
- R2: `ctl_clr` is 1 exactly when the decode/execute memory-read bit is 1 and its target register index equals the source index `id_rs` or the source index `id_rt` of the instruction held in fetch/decode.
- R3: While `ctl_clr` is 1, `pc_we` is 0 and the program counter keeps its value across the next clock edge.
- R4: While `ctl_clr` is 1, `ifid_we` is 0 and `id_rs`/`id_rt` keep their values across the next clock edge.
- R5: After a clock edge taken with `ctl_clr` at 1, the decode/execute memory-read, register-write and memory-write bits are all 0.
- R6: A stall lasts exactly one cycle. In the cycle after the bubble the stall is gone, and the held instruction then enters decode/execute with its own control bits.
- R7: A load whose target register index is 0 never causes a stall, whatever the source indices are.
- R8: Two back-to-back loads, where the second reads the first's target and the third instruction reads the second's target, produce two separate one-cycle bubbles. The program counter therefore advances by two over the four cycles that follow the first stall.
- R9: With no stall, the program counter advances by 1 on each edge, and decode/execute takes the fetch/decode control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_rs | input | RW | First source register index of the fetched instruction |
| fe_rt | input | RW | Second source / load target index of the fetched instruction |
| fe_ld | input | 1 | Fetched instruction reads data memory |
| fe_regwr | input | 1 | Fetched instruction writes the register file |
| fe_memwr | input | 1 | Fetched instruction writes data memory |
| pc_q | output | PCW | Program counter (instruction index) |
| id_rs | output | RW | First source index held in fetch/decode |
| id_rt | output | RW | Second source index held in fetch/decode |
| ex_rt | output | RW | Target index held in decode/execute |
| ex_memrd | output | 1 | Memory-read control in decode/execute |
| ex_regwr | output | 1 | Register-write control in decode/execute |
| ex_memwr | output | 1 | Memory-write control in decode/execute |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctl_clr | output | 1 | Bubble request: zeroes controls entering decode/execute |

## Verification
The bench builds the block with RW=3 and PCW=6, so the register file has only eight indices. This is small enough to sweep every load target against every pair of consumer sources, with the first instruction's memory-read flag both on and off. Every match, every mismatch and every case involving register 0 is covered in 1024 short programs. A separate program chains two dependent loads to show that each one gets its own single bubble.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef struct packed {
    logic memrd;
    logic regwr;
    logic memwr;
  } ctl_t;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/ldu_detect.sv
module ldu_detect #(
  parameter int RW = 5
) (
  input  logic                             ex_memrd,
  input  logic [RW-1:0]                    ex_rt,
  input  logic [ldu_pkg::NUM_SRC-1:0][RW-1:0] id_src,
  output logic                             pc_we,
  output logic                             ifid_we,
  output logic                             ctl_clr
);
  localparam int NS = ldu_pkg::NUM_SRC;
  logic [NS-1:0] hit;
  logic          stall;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign hit[g] = (id_src[g] == ex_rt);
  end

  // register 0 is hardwired, so a load into it never matters
  assign stall   = ex_memrd && (|hit) && (ex_rt != '0);
  assign pc_we   = !stall;
  assign ifid_we = !stall;
  assign ctl_clr = stall;
endmodule

// File: rtl/ldu_pc_reg.sv
module ldu_pc_reg #(
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  output logic [PCW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)     pc <= '0;
    else if (we) pc <= pc + PCW'(1);
  end
endmodule

// File: rtl/ldu_fd_reg.sv
module ldu_fd_reg #(
  parameter int RW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RW-1:0]  in_rs,
  input  logic [RW-1:0]  in_rt,
  input  ldu_pkg::ctl_t  in_ctl,
  output logic [RW-1:0]  q_rs,
  output logic [RW-1:0]  q_rt,
  output ldu_pkg::ctl_t  q_ctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_rs  <= '0;
      q_rt  <= '0;
      q_ctl <= '0;
    end else if (we) begin
      q_rs  <= in_rs;
      q_rt  <= in_rt;
      q_ctl <= in_ctl;
    end
  end
endmodule

// File: rtl/ldu_dx_reg.sv
module ldu_dx_reg #(
  parameter int RW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [RW-1:0]  in_rt,
  input  ldu_pkg::ctl_t  in_ctl,
  output logic [RW-1:0]  q_rt,
  output ldu_pkg::ctl_t  q_ctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_rt  <= '0;
      q_ctl <= '0;
    end else begin
      q_rt  <= in_rt;
      q_ctl <= clr ? ldu_pkg::ctl_t'('0) : in_ctl;
    end
  end
endmodule

// File: rtl/ldu_stall_pipe.sv
module ldu_stall_pipe #(
  parameter int RW  = 5,
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RW-1:0]  fe_rs,
  input  logic [RW-1:0]  fe_rt,
  input  logic           fe_ld,
  input  logic           fe_regwr,
  input  logic           fe_memwr,
  output logic [PCW-1:0] pc_q,
  output logic [RW-1:0]  id_rs,
  output logic [RW-1:0]  id_rt,
  output logic [RW-1:0]  ex_rt,
  output logic           ex_memrd,
  output logic           ex_regwr,
  output logic           ex_memwr,
  output logic           pc_we,
  output logic           ifid_we,
  output logic           ctl_clr
);
  import ldu_pkg::*;

  ctl_t fe_ctl, id_ctl, ex_ctl;
  logic [NUM_SRC-1:0][RW-1:0] id_src;

  assign fe_ctl = '{memrd: fe_ld, regwr: fe_regwr, memwr: fe_memwr};
  assign id_src = {id_rt, id_rs};

  ldu_pc_reg #(.PCW(PCW)) u_pc (
    .clk(clk), .rst(rst), .we(pc_we), .pc(pc_q)
  );

  ldu_fd_reg #(.RW(RW)) u_fd (
    .clk(clk), .rst(rst), .we(ifid_we),
    .in_rs(fe_rs), .in_rt(fe_rt), .in_ctl(fe_ctl),
    .q_rs(id_rs), .q_rt(id_rt), .q_ctl(id_ctl)
  );

  ldu_dx_reg #(.RW(RW)) u_dx (
    .clk(clk), .rst(rst), .clr(ctl_clr),
    .in_rt(id_rt), .in_ctl(id_ctl),
    .q_rt(ex_rt), .q_ctl(ex_ctl)
  );

  ldu_detect #(.RW(RW)) u_det (
    .ex_memrd(ex_ctl.memrd), .ex_rt(ex_rt), .id_src(id_src),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctl_clr(ctl_clr)
  );

  assign ex_memrd = ex_ctl.memrd;
  assign ex_regwr = ex_ctl.regwr;
  assign ex_memwr = ex_ctl.memwr;
endmodule

// File: rtl/ldu_stall_chk.sv
module ldu_stall_chk #(
  parameter int RW  = 5,
  parameter int PCW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] pc_q,
  input logic [RW-1:0]  id_rs,
  input logic [RW-1:0]  id_rt,
  input logic [RW-1:0]  ex_rt,
  input logic           ex_memrd,
  input logic           ex_regwr,
  input logic           ex_memwr,
  input logic           pc_we,
  input logic           ifid_we,
  input logic           ctl_clr
);
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |-> (!pc_we ##1 pc_q == $past(pc_q)));
  p_ifid_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |=> ($stable(id_rs) && $stable(id_rt)));
  p_ifid_we_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |-> !ifid_we);
  p_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |=> (!ex_memrd && !ex_regwr && !ex_memwr));
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |=> !ctl_clr);
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
    (ex_rt == '0) |-> !ctl_clr);
  p_advance_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_clr |=> ((pc_q - $past(pc_q)) == PCW'(1)));
endmodule

bind ldu_stall_pipe ldu_stall_chk #(.RW(RW), .PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .pc_q(pc_q), .id_rs(id_rs), .id_rt(id_rt),
  .ex_rt(ex_rt), .ex_memrd(ex_memrd), .ex_regwr(ex_regwr),
  .ex_memwr(ex_memwr), .pc_we(pc_we), .ifid_we(ifid_we), .ctl_clr(ctl_clr)
);

// File: tb/test_ldu_stall_pipe.sv
module test_ldu_stall_pipe;
  localparam int RW  = 3;
  localparam int PCW = 6;
  localparam int NR  = 1 << RW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0]  fe_rs, fe_rt;
  logic           fe_ld, fe_regwr, fe_memwr;
  logic [PCW-1:0] pc_q;
  logic [RW-1:0]  id_rs, id_rt, ex_rt;
  logic ex_memrd, ex_regwr, ex_memwr, pc_we, ifid_we, ctl_clr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scenario program selection
  int sc_mode = 0;
  logic sc_ld = 1'b0;
  logic [RW-1:0] sc_l = '0, sc_a = '0, sc_b = '0;

  always #4 clk = ~clk;

  ldu_stall_pipe #(.RW(RW), .PCW(PCW)) i_ldu_stall_pipe (
    .clk(clk), .rst(rst), .fe_rs(fe_rs), .fe_rt(fe_rt), .fe_ld(fe_ld),
    .fe_regwr(fe_regwr), .fe_memwr(fe_memwr), .pc_q(pc_q), .id_rs(id_rs),
    .id_rt(id_rt), .ex_rt(ex_rt), .ex_memrd(ex_memrd), .ex_regwr(ex_regwr),
    .ex_memwr(ex_memwr), .pc_we(pc_we), .ifid_we(ifid_we), .ctl_clr(ctl_clr)
  );

  // instruction memory model
  always_comb begin
    {fe_rs, fe_rt, fe_ld, fe_regwr, fe_memwr} = '0;
    if (sc_mode == 0) begin
      if (pc_q == 0) begin fe_rt = sc_l; fe_ld = sc_ld; fe_regwr = 1'b1; end
      else if (pc_q == 1) begin
        fe_rs = sc_a; fe_rt = sc_b; fe_regwr = 1'b1; fe_memwr = 1'b1;
      end
    end else begin
      if (pc_q == 0) begin fe_rt = 3'd5; fe_ld = 1'b1; fe_regwr = 1'b1; end
      else if (pc_q == 1) begin
        fe_rs = 3'd5; fe_rt = 3'd6; fe_ld = 1'b1; fe_regwr = 1'b1;
      end else if (pc_q == 2) begin
        fe_rs = 3'd6; fe_rt = 3'd1; fe_regwr = 1'b1; fe_memwr = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d ld %0d l %0d a %0d b %0d)",
               req, act, exp, sc_mode, sc_ld, sc_l, sc_a, sc_b);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    // R1: reset state
    chk(pc_q == 0, "R1 pc", int'(pc_q), 0);
    chk({ex_memrd, ex_regwr, ex_memwr} == 3'b000, "R1 ex ctl",
        int'({ex_memrd, ex_regwr, ex_memwr}), 0);
    chk(!ctl_clr && pc_we && ifid_we, "R1 stall", int'(ctl_clr), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // exhaustive sweep: load target vs consumer sources
    for (int ld = 0; ld < 2; ld++)
      for (int l = 0; l < NR; l++)
        for (int a = 0; a < NR; a++)
          for (int b = 0; b < NR; b++) begin
            bit exp;
            string tag;
            sc_mode = 0;
            sc_ld = ld[0]; sc_l = l[RW-1:0]; sc_a = a[RW-1:0]; sc_b = b[RW-1:0];
            exp = (ld == 1) && (l != 0) && (a == l || b == l);
            tag = (l == 0) ? "R7 zero reg" : "R2 detect";
            do_reset();
            step(); // instr0 into fetch/decode
            step(); // instr0 in execute, instr1 in decode
            chk(pc_q == 2, "R9 pc advance", int'(pc_q), 2);
            chk(ctl_clr == exp, tag, int'(ctl_clr), int'(exp));
            step();
            if (exp) begin
              chk(pc_q == 2, "R3 pc hold", int'(pc_q), 2);
              chk(id_rs == sc_a && id_rt == sc_b, "R4 ifid hold",
                  int'({id_rs, id_rt}), int'({sc_a, sc_b}));
              chk({ex_memrd, ex_regwr, ex_memwr} == 3'b000, "R5 bubble",
                  int'({ex_memrd, ex_regwr, ex_memwr}), 0);
              chk(!ctl_clr, "R6 clear", int'(ctl_clr), 0);
              step();
              chk(pc_q == 3, "R6 resume pc", int'(pc_q), 3);
              chk({ex_memrd, ex_regwr, ex_memwr} == 3'b011, "R6 consumer ctl",
                  int'({ex_memrd, ex_regwr, ex_memwr}), 3);
            end else begin
              chk(pc_q == 3, "R9 pc advance", int'(pc_q), 3);
              chk({ex_memrd, ex_regwr, ex_memwr} == 3'b011, "R9 pass ctl",
                  int'({ex_memrd, ex_regwr, ex_memwr}), 3);
            end
          end

    // back-to-back dependent loads
    begin
      int stalls;
      int exp_pc[5] = '{2, 2, 3, 3, 4};
      int exp_st[5] = '{1, 0, 1, 0, 0};
      sc_mode = 1; sc_ld = 1'b0; sc_l = '0; sc_a = '0; sc_b = '0;
      do_reset();
      step();
      step();
      stalls = 0;
      for (int k = 0; k < 5; k++) begin
        chk(pc_q == PCW'(exp_pc[k]), "R8 pc", int'(pc_q), exp_pc[k]);
        chk(ctl_clr == exp_st[k][0], "R8 stall", int'(ctl_clr), exp_st[k]);
        if (ctl_clr) stalls++;
        step();
      end
      chk(stalls == 2, "R8 bubble count", stalls, 2);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule